// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block turns single-word host reads and writes into the strobe sequences that an asynchronous, address-multiplexed DRAM expects. A request carries a flat word address, a write flag, per-byte enables and write data. The sequencer splits the address into a row part and a column part. It presents the row on the shared address pins when the row strobe falls. It presents the column when the column strobes fall. Each data byte has its own column strobe, so the byte enables act as byte selects on the wide data bus.

After an access the row stays open. A later request to the same row is served as a short column-only cycle. A request to another row first raises the row strobe and holds it high for the precharge time, then opens the new row. A parameter selects one of two read timings:
- **Fast-page timing:** read data is taken while the column strobe is still low.
- **Extended-data-out timing:** read data is taken one clock after the column strobe rises, because the device keeps driving its outputs.

Writes are always issued as early writes. The write strobe falls one cycle before the column strobe, so the device keeps its outputs off. Output enable stays high for the whole write.

Top module: `pgdram_ctrl`

## Requirements
- R1: While reset is asserted, the outputs are as follows. `dram_ras_n`, every `dram_cas_n` bit, `dram_we_n` and `dram_oe_n` are 1. `dram_dq_oe` and `rsp_valid` are 0. `req_ready` is 1.
- R2: `req_addr[20:10]` is the row and `req_addr[9:0]` is the column. When `dram_ras_n` falls, `dram_addr` holds the row. When the column strobes fall, `dram_addr` holds the column, zero-extended.
- R3: The column strobes fall only while `dram_ras_n` is low, and no earlier than RCD_CYC+1 cycles after it fell.
- R4: While a row is open, a request to that row causes no row-strobe activity. `dram_ras_n` falls exactly once for each request that finds no row open or a different row open.
- R5: Before every fall, `dram_ras_n` has been high for at least RP_CYC consecutive cycles.
- R6: For a write, `dram_we_n` is low in the cycle before the column strobes fall and while they are low. `dram_oe_n` is high whenever `dram_we_n` is low. `dram_dq_oe` is 1 and `dram_dq_out` equals the write data while the column strobes are low.
- R7: `dram_cas_n[b]` goes low only when `req_be[b]` is 1. Bit b selects `dram_dq[8b+7:8b]`. A write leaves the unselected bytes of the word unchanged.
- R8: For a read, `dram_we_n` stays high and `dram_oe_n` is low from the column setup cycle through the cycle after the column strobes rise.
- R9: With EDO_MODE=1, read data is sampled at the end of the cycle after the column strobes rise. `rsp_valid` is then high CAS_CYC+2 cycles after a page-hit accept, or RP_CYC+RCD_CYC+CAS_CYC+2 cycles after a miss accept.
- R10: With EDO_MODE=0, read data is sampled at the end of the last strobe-low cycle. The response comes CAS_CYC+1 cycles after a hit accept, or RP_CYC+RCD_CYC+CAS_CYC+1 cycles after a miss accept.
- R11: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the cycle after an accept. Each read gives exactly one single-cycle `rsp_valid` pulse. Writes give none.
- R12: The column strobes stay low for exactly CAS_CYC cycles. They are then high for at least one cycle before they can fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address, row in the upper 11 bits |
| req_be | input | 8 | Byte enables |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 64 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 8 | Per-byte column strobes, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 64 | Data driven toward the device |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 64 | Data returned by the device |

## Verification
All counts below are clock edges after the accept edge, with the default timing (RP_CYC=2, RCD_CYC=2, CAS_CYC=2):

| Access | Extended-data-out instance | Fast-page instance |
|---|---|---|
| Page hit | 4 | 3 |
| Miss | 8 | 7 |

Two instances, one per read timing, run the same request stream. Each has its own device stub. For every read, the driver records the edge number on which the response is due. The monitor compares that number with the edge counter when it samples `rsp_valid` at the falling clock edge. The stub drives junk whenever the device would not be driving, so a sample taken one cycle early or late returns the wrong data. The strobe order, the precharge and row-to-column gaps, and the address phases are measured on the pins at each falling clock edge.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PRE    = 3'd1,
        ST_ROW    = 3'd2,
        ST_COLSET = 3'd3,
        ST_CASLO  = 3'd4,
        ST_CASHI  = 3'd5
    } seq_st_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pgdram_rowtrk.sv
module pgdram_rowtrk #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set_i,
    input  logic             open_clr_i,
    input  logic [ROW_W-1:0] set_row_i,
    input  logic [ROW_W-1:0] cmp_row_i,
    output logic             page_open_o,
    output logic             page_hit_o
);
    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } trk_s;

    trk_s trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (open_clr_i) trk_d.open = 1'b0;
        if (open_set_i) begin
            trk_d.open = 1'b1;
            trk_d.row  = set_row_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign page_open_o = trk_q.open;
    assign page_hit_o  = trk_q.open && (trk_q.row == cmp_row_i);

    // R4/R5: a page is never opened and closed in the same cycle
    a_r5_open_close_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_set_i && open_clr_i));

endmodule

// File: rtl/pgdram_rdcap.sv
module pgdram_rdcap #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } cap_s;

    cap_s cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = smp_i;
        if (smp_i) cap_d.data = dq_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rsp_valid_o = cap_q.vld;
    assign rsp_data_o  = cap_q.data;

    // R11: each read response is a single-cycle pulse
    a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.vld |=> !cap_q.vld);

endmodule

// File: rtl/pgdram_seq.sv
module pgdram_seq
    import pgdram_pkg::*;
#(
    parameter int ROW_W    = 11,
    parameter int COL_W    = 10,
    parameter int DATA_W   = 64,
    parameter int RP_CYC   = 2,
    parameter int RCD_CYC  = 2,
    parameter int CAS_CYC  = 2,
    parameter bit EDO_MODE = 1'b1,
    localparam int BYTES   = DATA_W / 8,
    localparam int AW      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_we,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [BYTES-1:0]       req_be,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic                   page_open_i,
    input  logic                   page_hit_i,
    output logic                   open_set_o,
    output logic                   open_clr_o,
    output logic [ROW_W-1:0]       open_row_o,
    output logic                   ras_n,
    output logic [BYTES-1:0]       cas_n,
    output logic                   we_n,
    output logic                   oe_n,
    output logic [AW-1:0]          addr,
    output logic [DATA_W-1:0]      dq_out,
    output logic                   dq_oe,
    output logic                   smp_o
);
    localparam int CMAX  = max3(RP_CYC, RCD_CYC, CAS_CYC);
    localparam int CNT_W = (CMAX > 1) ? $clog2(CMAX) : 1;
    localparam int KW    = CNT_W + 2;

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic              we;
        logic [BYTES-1:0]  be;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wd;
        logic              ras_n;
        logic [BYTES-1:0]  cas_n;
        logic              we_n;
        logic              oe_n;
        logic [AW-1:0]     addr;
        logic              dq_oe;
    } seq_s;

    seq_s s_d, s_q;

    function automatic seq_s col_setup(input seq_s s);
        seq_s r;
        r       = s;
        r.st    = ST_COLSET;
        r.ras_n = 1'b0;
        r.cas_n = '1;
        r.addr  = AW'(s.col);
        r.we_n  = ~s.we;
        r.oe_n  = s.we;
        r.dq_oe = s.we;
        return r;
    endfunction

    always_comb begin
        s_d        = s_q;
        open_set_o = 1'b0;
        open_clr_o = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.we  = req_we;
                    s_d.be  = req_be;
                    s_d.row = req_addr[ROW_W+COL_W-1:COL_W];
                    s_d.col = req_addr[COL_W-1:0];
                    s_d.wd  = req_wdata;
                    if (page_open_i && page_hit_i) begin
                        s_d = col_setup(s_d);
                    end else begin
                        s_d.st     = ST_PRE;
                        s_d.ras_n  = 1'b1;
                        s_d.cnt    = CNT_W'(RP_CYC - 1);
                        open_clr_o = 1'b1;
                    end
                end
            end
            ST_PRE: begin
                if (s_q.cnt == '0) begin
                    s_d.st     = ST_ROW;
                    s_d.ras_n  = 1'b0;
                    s_d.addr   = AW'(s_q.row);
                    s_d.cnt    = CNT_W'(RCD_CYC - 1);
                    open_set_o = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                    s_d.addr = AW'(s_q.row);
                end
            end
            ST_ROW: begin
                if (s_q.cnt == '0) s_d = col_setup(s_q);
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            ST_COLSET: begin
                s_d.st    = ST_CASLO;
                s_d.cas_n = ~s_q.be;
                s_d.cnt   = CNT_W'(CAS_CYC - 1);
            end
            ST_CASLO: begin
                if (s_q.cnt == '0) begin
                    s_d.st    = ST_CASHI;
                    s_d.cas_n = '1;
                    s_d.we_n  = 1'b1;
                    s_d.dq_oe = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_CASHI: begin
                s_d.st   = ST_IDLE;
                s_d.oe_n = 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
            s_q.ras_n <= 1'b1;
            s_q.cas_n <= '1;
            s_q.we_n  <= 1'b1;
            s_q.oe_n  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready  = (s_q.st == ST_IDLE);
    assign open_row_o = s_q.row;
    assign ras_n      = s_q.ras_n;
    assign cas_n      = s_q.cas_n;
    assign we_n       = s_q.we_n;
    assign oe_n       = s_q.oe_n;
    assign addr       = s_q.addr;
    assign dq_out     = s_q.wd;
    assign dq_oe      = s_q.dq_oe;

    generate
        if (EDO_MODE) begin : g_edo
            assign smp_o = (s_q.st == ST_CASHI) && !s_q.we;
        end else begin : g_fpm
            assign smp_o = (s_q.st == ST_CASLO) && (s_q.cnt == '0) && !s_q.we;
        end
    endgenerate

    // checker state: run lengths of the row strobe
    logic [KW-1:0] hi_run_q, lo_run_q;
    logic          cas_idle;
    assign cas_idle = &s_q.cas_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else if (s_q.ras_n) begin
            hi_run_q <= (&hi_run_q) ? hi_run_q : hi_run_q + 1'b1;
            lo_run_q <= '0;
        end else begin
            lo_run_q <= (&lo_run_q) ? lo_run_q : lo_run_q + 1'b1;
            hi_run_q <= '0;
        end
    end

    a_r5_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.ras_n) |-> (hi_run_q >= KW'(RP_CYC)));
    a_r3_ras_to_cas: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_idle) |-> (!s_q.ras_n && lo_run_q >= KW'(RCD_CYC + 1)));
    a_r6_we_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_idle) && !s_q.we_n) |-> $past(!s_q.we_n));
    a_r6_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.we_n |-> s_q.oe_n);
    a_r12_cas_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_idle) |=> cas_idle);
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl #(
    parameter int ROW_W    = 11,
    parameter int COL_W    = 10,
    parameter int DATA_W   = 64,
    parameter int RP_CYC   = 2,
    parameter int RCD_CYC  = 2,
    parameter int CAS_CYC  = 2,
    parameter bit EDO_MODE = 1'b1,
    localparam int BYTES   = DATA_W / 8,
    localparam int AW      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_we,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [BYTES-1:0]       req_be,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   dram_ras_n,
    output logic [BYTES-1:0]       dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [AW-1:0]          dram_addr,
    output logic [DATA_W-1:0]      dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DATA_W-1:0]      dram_dq_in
);
    logic             page_open, page_hit, open_set, open_clr, smp;
    logic [ROW_W-1:0] open_row;

    pgdram_rowtrk #(.ROW_W(ROW_W)) u_rowtrk (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_set_i  (open_set),
        .open_clr_i  (open_clr),
        .set_row_i   (open_row),
        .cmp_row_i   (req_addr[ROW_W+COL_W-1:COL_W]),
        .page_open_o (page_open),
        .page_hit_o  (page_hit)
    );

    pgdram_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .RP_CYC(RP_CYC), .RCD_CYC(RCD_CYC), .CAS_CYC(CAS_CYC),
        .EDO_MODE(EDO_MODE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_we      (req_we),
        .req_addr    (req_addr),
        .req_be      (req_be),
        .req_wdata   (req_wdata),
        .page_open_i (page_open),
        .page_hit_i  (page_hit),
        .open_set_o  (open_set),
        .open_clr_o  (open_clr),
        .open_row_o  (open_row),
        .ras_n       (dram_ras_n),
        .cas_n       (dram_cas_n),
        .we_n        (dram_we_n),
        .oe_n        (dram_oe_n),
        .addr        (dram_addr),
        .dq_out      (dram_dq_out),
        .dq_oe       (dram_dq_oe),
        .smp_o       (smp)
    );

    pgdram_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_i       (smp),
        .dq_i        (dram_dq_in),
        .rsp_valid_o (rsp_valid),
        .rsp_data_o  (rsp_rdata)
    );

endmodule

// File: tb/pgdram_ctrl_tb.sv
`timescale 1ns/1ps

module pgdram_stub #(
    parameter int ROW_W = 11,
    parameter int COL_W = 10,
    parameter int DATA_W = 64,
    parameter bit EDO = 1'b1
) (
    input  logic                  clk,
    input  logic                  ras_n,
    input  logic [DATA_W/8-1:0]   cas_n,
    input  logic                  we_n,
    input  logic                  oe_n,
    input  logic [ROW_W-1:0]      addr,
    input  logic [DATA_W-1:0]     dq_out,
    input  logic                  dq_oe,
    output logic [DATA_W-1:0]     dq_in
);
    localparam logic [DATA_W-1:0] JUNK = {(DATA_W/8){8'hA5}};
    logic [DATA_W-1:0] mem [int];
    logic [DATA_W-1:0] held, word;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic              p_ras, p_cas_lo, hold_ok, cas_lo;
    int                idx;

    initial begin
        dq_in = JUNK; p_ras = 1'b1; p_cas_lo = 1'b0; hold_ok = 1'b0;
        held = '0; row = '0; col = '0;
    end

    always @(negedge clk) begin
        cas_lo = ~&cas_n;
        if (p_ras && !ras_n) row = addr;
        if (cas_lo && !p_cas_lo) begin
            col = addr[COL_W-1:0];
            idx = int'({row, col});
            word = mem.exists(idx) ? mem[idx] : '0;
            if (!we_n) begin
                for (int b = 0; b < DATA_W/8; b++)
                    if (!cas_n[b]) word[b*8 +: 8] = dq_oe ? dq_out[b*8 +: 8] : 8'hA5;
                mem[idx] = word;
                hold_ok = 1'b0;
            end else begin
                held = word;
                hold_ok = 1'b1;
            end
        end
        if (ras_n || oe_n || !we_n) hold_ok = 1'b0;
        if (!ras_n && !oe_n && we_n && (cas_lo || (EDO && hold_ok))) dq_in <= held;
        else dq_in <= JUNK;
        p_ras = ras_n;
        p_cas_lo = cas_lo;
    end
endmodule

module pgdram_ctrl_tb;
    localparam int ROW_W = 11, COL_W = 10, DATA_W = 64, BYTES = 8;
    localparam int RP = 2, RCD = 2, CASC = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, req_valid, req_we;
    logic [ROW_W+COL_W-1:0] req_addr;
    logic [BYTES-1:0] req_be;
    logic [DATA_W-1:0] req_wdata;

    logic e_ready, e_rv, e_ras, e_we, e_oe, e_dqoe;
    logic [DATA_W-1:0] e_rd, e_dqo, e_dqi;
    logic [BYTES-1:0] e_cas;
    logic [ROW_W-1:0] e_addr;
    logic f_ready, f_rv, f_ras, f_we, f_oe, f_dqoe;
    logic [DATA_W-1:0] f_rd, f_dqo, f_dqi;
    logic [BYTES-1:0] f_cas;
    logic [ROW_W-1:0] f_addr;

    pgdram_ctrl #(.EDO_MODE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(e_ready),
        .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(e_rv), .rsp_rdata(e_rd), .dram_ras_n(e_ras), .dram_cas_n(e_cas),
        .dram_we_n(e_we), .dram_oe_n(e_oe), .dram_addr(e_addr), .dram_dq_out(e_dqo),
        .dram_dq_oe(e_dqoe), .dram_dq_in(e_dqi));
    pgdram_stub #(.EDO(1'b1)) u_stub_e (
        .clk(clk), .ras_n(e_ras), .cas_n(e_cas), .we_n(e_we), .oe_n(e_oe),
        .addr(e_addr), .dq_out(e_dqo), .dq_oe(e_dqoe), .dq_in(e_dqi));

    pgdram_ctrl #(.EDO_MODE(1'b0)) u_fpm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(f_ready),
        .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(f_rv), .rsp_rdata(f_rd), .dram_ras_n(f_ras), .dram_cas_n(f_cas),
        .dram_we_n(f_we), .dram_oe_n(f_oe), .dram_addr(f_addr), .dram_dq_out(f_dqo),
        .dram_dq_oe(f_dqoe), .dram_dq_in(f_dqi));
    pgdram_stub #(.EDO(1'b0)) u_stub_f (
        .clk(clk), .ras_n(f_ras), .cas_n(f_cas), .we_n(f_we), .oe_n(f_oe),
        .addr(f_addr), .dq_out(f_dqo), .dq_oe(f_dqoe), .dq_in(f_dqi));

    typedef struct { longint due; logic [DATA_W-1:0] data; } exp_t;
    exp_t q_e[$], q_f[$];
    logic [DATA_W-1:0] model [int];

    int checks = 0, fails = 0;
    longint cyc = 0;
    bit open_tb = 0;
    logic [ROW_W-1:0] open_row = '0, cur_row = '0;
    logic [COL_W-1:0] cur_col = '0;
    logic [BYTES-1:0] cur_be = '0;
    logic cur_we = 1'b0;
    logic [DATA_W-1:0] cur_wd = '0;
    int ras_falls = 0, exp_opens = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic we, input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c,
                          input logic [BYTES-1:0] be, input logic [DATA_W-1:0] wd);
        bit hit;
        int idx;
        exp_t it;
        logic [DATA_W-1:0] w;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = {r, c}; req_be = be; req_wdata = wd;
        while (!e_ready) @(negedge clk);
        chk(e_ready == f_ready, "R11 ready mismatch", 64'(f_ready), 64'(e_ready));
        hit = open_tb && (open_row == r);
        cur_row = r; cur_col = c; cur_be = be; cur_we = we; cur_wd = wd;
        if (!hit) exp_opens++;
        idx = int'({r, c});
        w = model.exists(idx) ? model[idx] : '0;
        if (we) begin
            for (int b = 0; b < BYTES; b++) if (be[b]) w[b*8 +: 8] = wd[b*8 +: 8];
            model[idx] = w;
        end else begin
            it.data = w;
            it.due = cyc + 1 + (hit ? 0 : RP + RCD) + CASC + 2;
            q_e.push_back(it);
            it.due = cyc + 1 + (hit ? 0 : RP + RCD) + CASC + 1;
            q_f.push_back(it);
        end
        open_tb = 1; open_row = r;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!e_ready, "R11 ready after accept", 64'(e_ready), 64'd0);
    endtask

    // scoreboard monitors
    always @(negedge clk) if (rst_n && e_rv) begin
        exp_t it;
        if (q_e.size() == 0) chk(0, "R11 unexpected edo rsp", e_rd, 64'd0);
        else begin
            it = q_e.pop_front();
            chk(e_rd == it.data, "R9 edo read data", e_rd, it.data);
            chk(cyc == it.due, "R9 edo latency", 64'(cyc), 64'(it.due));
        end
    end
    always @(negedge clk) if (rst_n && f_rv) begin
        exp_t it;
        if (q_f.size() == 0) chk(0, "R11 unexpected fpm rsp", f_rd, 64'd0);
        else begin
            it = q_f.pop_front();
            chk(f_rd == it.data, "R10 fpm read data", f_rd, it.data);
            chk(cyc == it.due, "R10 fpm latency", 64'(cyc), 64'(it.due));
        end
    end

    // pin monitor on the EDO instance
    logic p_ras = 1'b1, p_cas_lo = 1'b0, p_we = 1'b1;
    int hi_run = 0, lo_run = 0, cas_lo_run = 0;
    always @(negedge clk) if (rst_n) begin
        logic cas_lo;
        cas_lo = ~&e_cas;
        if (p_ras && !e_ras) begin
            ras_falls++;
            chk(hi_run >= RP, "R5 precharge", 64'(hi_run), 64'(RP));
            chk(e_addr == cur_row, "R2 row phase", 64'(e_addr), 64'(cur_row));
        end
        if (cas_lo && !p_cas_lo) begin
            chk(!e_ras && lo_run >= RCD + 1, "R3 ras to cas", 64'(lo_run), 64'(RCD + 1));
            chk(e_addr == ROW_W'(cur_col), "R2 col phase", 64'(e_addr), 64'(cur_col));
            chk(e_cas == ~cur_be, "R7 byte strobes", 64'(e_cas), 64'(~cur_be));
            if (cur_we) begin
                chk(!p_we && !e_we, "R6 early write", 64'({p_we, e_we}), 64'd0);
                chk(e_dqoe && e_dqo == cur_wd, "R6 write data", e_dqo, cur_wd);
            end else begin
                chk(!e_oe && e_we, "R8 read controls", 64'({e_oe, e_we}), 64'b01);
            end
        end
        if (!cas_lo && p_cas_lo) begin
            chk(cas_lo_run == CASC, "R12 cas width", 64'(cas_lo_run), 64'(CASC));
            if (!cur_we) chk(!e_oe && e_we, "R8 oe after cas rise", 64'({e_oe, e_we}), 64'b01);
        end
        if (!e_we) chk(e_oe, "R6 oe off in write", 64'(e_oe), 64'd1);
        if (e_ras) begin hi_run++; lo_run = 0; end else begin lo_run++; hi_run = 0; end
        cas_lo_run = cas_lo ? cas_lo_run + 1 : 0;
        p_ras = e_ras; p_cas_lo = cas_lo; p_we = e_we;
    end

    bit done = 0;
    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_be = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk(e_ras && f_ras, "R1 ras idle", 64'({e_ras, f_ras}), 64'b11);
        chk(&{e_cas, f_cas}, "R1 cas idle", 64'({e_cas, f_cas}), 64'hFFFF);
        chk(e_we && e_oe && !e_dqoe, "R1 we/oe/dq", 64'({e_we, e_oe, e_dqoe}), 64'b110);
        chk(e_ready && f_ready && !e_rv && !f_rv, "R1 handshake", 64'({e_ready, f_ready, e_rv, f_rv}), 64'b1100);
        rst_n = 1'b1;
        // first access (closed), then page hits
        do_req(1'b1, 11'd5, 10'd3, 8'hFF, 64'h0123_4567_89AB_CDEF);
        do_req(1'b0, 11'd5, 10'd3, 8'hFF, '0);
        do_req(1'b1, 11'd5, 10'd4, 8'hFF, 64'h1111_2222_3333_4444);
        // R7 partial byte write then merged read
        do_req(1'b1, 11'd5, 10'd4, 8'h0F, 64'hAAAA_BBBB_CCCC_DDDD);
        do_req(1'b0, 11'd5, 10'd4, 8'hFF, '0);
        do_req(1'b1, 11'd5, 10'd4, 8'h81, 64'h7700_0000_0000_0066);
        do_req(1'b0, 11'd5, 10'd4, 8'hFF, '0);
        // R5 row change in both directions
        do_req(1'b1, 11'd9, 10'd3, 8'hFF, 64'hFEED_FACE_0BAD_F00D);
        do_req(1'b0, 11'd5, 10'd3, 8'hFF, '0);
        do_req(1'b0, 11'd9, 10'd3, 8'hFF, '0);
        // run of hits
        for (int i = 0; i < 4; i++) do_req(1'b0, 11'd9, 10'(i + 1), 8'hFF, '0);
        // address extremes
        do_req(1'b1, 11'h7FF, 10'h3FF, 8'hFF, 64'hDEAD_BEEF_CAFE_0001);
        do_req(1'b1, 11'h000, 10'h000, 8'hFF, 64'h0000_0000_0000_0002);
        do_req(1'b0, 11'h7FF, 10'h3FF, 8'hFF, '0);
        do_req(1'b0, 11'h000, 10'h000, 8'hFF, '0);
        repeat (20) @(negedge clk);
        chk(q_e.size() == 0, "R9 pending edo responses", 64'(q_e.size()), 64'd0);
        chk(q_f.size() == 0, "R10 pending fpm responses", 64'(q_f.size()), 64'd0);
        chk(ras_falls == exp_opens, "R4 row opens", 64'(ras_falls), 64'(exp_opens));
        done = 1;
        finish_run();
    end
endmodule